// File: doc/BRIEF.md
# Exception Entry and Status Stack Unit

This block is the control-register corner of a small 32-bit in-order core. It handles the two synchronous software traps, system call and breakpoint, and the matching return-from-exception operation. When the pipeline raises a trap, the block does four things. It records why the trap happened and where, pushes the privilege/interrupt state onto a small stack held in the status word, and one cycle later asks the fetch stage to jump to a handler vector.

The status word keeps three pairs of bits: a user-mode flag (odd bit) and an interrupt-enable flag (even bit). The pair in bits 1:0 is the live one. Taking a trap moves every pair up one level and zeroes the live pair, so the handler runs in kernel mode with interrupts off. A return operation moves them back down one level and leaves the oldest pair where it was.

The pipeline reaches Status, Cause and the exception return address (EPC) through a move-to and a move-from port. Register numbers 12, 13 and 14 select them.

Top module: `exc_status_unit`

## Requirements
- R1: While reset is held and just after it, Status reads 0x0040_0000, Cause and EPC read zero, and redirect_valid, int_enable and user_mode are all 0.
- R2: A trap with trap_kind = 0 (system call) writes 8 into Cause bits 6:2. Cause bits 30:7 and 1:0 keep their old values.
- R3: A trap with trap_kind = 1 (breakpoint) writes 9 into Cause bits 6:2. The other Cause bits behave as in R2.
- R4: A trap with trap_in_delay = 0 loads EPC with trap_pc and clears Cause bit 31.
- R5: A trap with trap_in_delay = 1 loads EPC with trap_pc minus 4 and sets Cause bit 31.
- R6: On a trap, Status bits 5:0 become the old bits 3:0 shifted left by two, with bits 1:0 zero. Status bits 31:6 do not change.
- R7: On rfe_valid without a trap, Status bits 3:0 take the old bits 5:2, and Status bits 31:4 do not change.
- R8: redirect_valid is high for exactly the one cycle after each trap cycle. During that cycle redirect_vector is 0xBFC0_0180 if Status bit 22 was set when the trap was taken, and 0x8000_0080 if it was clear.
- R9: With cop_wr_en high, register numbers 12, 13 and 14 write Status, Cause and EPC with cop_wdata, taking effect at the next edge. cop_rdata returns the selected register combinationally. Writes to any other number change nothing, and reads of any other number return zero.
- R10: A trap in the same cycle as rfe_valid or a write is the only action taken in that cycle. An rfe_valid in the same cycle as a write drops the write.
- R11: int_enable always equals Status bit 0 and user_mode always equals Status bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| trap_valid | input | 1 | A trap is taken this cycle |
| trap_kind | input | 1 | 0 = system call, 1 = breakpoint |
| trap_pc | input | 32 | Address of the trapping instruction |
| trap_in_delay | input | 1 | Trapping instruction sits in a branch delay slot |
| rfe_valid | input | 1 | Return-from-exception: pop the status stack |
| cop_wr_en | input | 1 | Move-to-control-register strobe |
| cop_addr | input | 5 | Control register number for read and write |
| cop_wdata | input | 32 | Data for a control register write |
| cop_rdata | output | 32 | Contents of the selected control register |
| redirect_valid | output | 1 | Fetch must jump to redirect_vector |
| redirect_vector | output | 32 | Handler entry address |
| int_enable | output | 1 | Live interrupt-enable bit |
| user_mode | output | 1 | Live user-mode bit |

## Verification
The bench targets cycles where a trap, a return and a write arrive together. A design with the priorities wrong would let a stray write clobber the freshly pushed Status or the recorded Cause. Delay-slot traps are mixed with ordinary ones. An EPC off by four or a stale Cause bit 31 shows up when the registers are read back. Random Status writes flip the boot-vector bit between traps, which catches a vector picked from the wrong cycle's Status. Repeated returns with no traps in between check that the oldest pair is kept, not shifted in as zero. Reads and writes to unmapped numbers catch a decoder that aliases neighbouring registers.

// File: rtl/exc_pkg.sv
package exc_pkg;
    localparam int XLEN      = 32;
    localparam int REG_ADDR_W = 5;

    localparam logic [REG_ADDR_W-1:0] REG_STATUS = 5'd12;
    localparam logic [REG_ADDR_W-1:0] REG_CAUSE  = 5'd13;
    localparam logic [REG_ADDR_W-1:0] REG_EPC    = 5'd14;

    localparam logic [4:0] CODE_SYSCALL = 5'd8;
    localparam logic [4:0] CODE_BREAK   = 5'd9;

    typedef enum logic {
        TRAP_SYSCALL = 1'b0,
        TRAP_BREAK   = 1'b1
    } trap_kind_e;

    typedef struct packed {
        logic [XLEN-1:0] status;
        logic [XLEN-1:0] cause;
        logic [XLEN-1:0] epc;
        logic            redir_valid;
        logic [XLEN-1:0] redir_vec;
    } exc_state_t;
endpackage

// File: rtl/exc_status_stack.sv
module exc_status_stack #(
    parameter int LEVELS = 3
) (
    input  logic [exc_pkg::XLEN-1:0] status_in,
    input  logic                     push,
    input  logic                     pop,
    output logic [exc_pkg::XLEN-1:0] status_out
);
    localparam int SW = 2 * LEVELS;

    logic [SW-1:0] pushed;
    logic [SW-1:0] popped;

    for (genvar g = 0; g < LEVELS; g++) begin : g_pair
        if (g == 0) begin : g_low
            assign pushed[1:0] = 2'b00;
        end else begin : g_up
            assign pushed[2*g+1:2*g] = status_in[2*g-1:2*g-2];
        end
        if (g == LEVELS - 1) begin : g_top
            assign popped[2*g+1:2*g] = status_in[2*g+1:2*g];
        end else begin : g_down
            assign popped[2*g+1:2*g] = status_in[2*g+3:2*g+2];
        end
    end

    always_comb begin
        if (push) begin
            status_out = {status_in[exc_pkg::XLEN-1:SW], pushed};
        end else if (pop) begin
            status_out = {status_in[exc_pkg::XLEN-1:SW], popped};
        end else begin
            status_out = status_in;
        end
    end
endmodule

// File: rtl/exc_trap_record.sv
module exc_trap_record (
    input  logic [exc_pkg::XLEN-1:0] cause_in,
    input  exc_pkg::trap_kind_e      kind,
    input  logic [exc_pkg::XLEN-1:0] pc,
    input  logic                     in_delay,
    output logic [exc_pkg::XLEN-1:0] cause_out,
    output logic [exc_pkg::XLEN-1:0] epc_out
);
    import exc_pkg::*;

    logic [4:0] code;

    always_comb begin
        code      = (kind == TRAP_BREAK) ? CODE_BREAK : CODE_SYSCALL;
        cause_out = {in_delay, cause_in[XLEN-2:7], code, cause_in[1:0]};
        epc_out   = in_delay ? (pc - XLEN'(4)) : pc;
    end
endmodule

// File: rtl/exc_vector_sel.sv
module exc_vector_sel #(
    parameter int                        BEV_BIT = 22,
    parameter logic [exc_pkg::XLEN-1:0] VEC_RAM = 32'h8000_0080,
    parameter logic [exc_pkg::XLEN-1:0] VEC_ROM = 32'hBFC0_0180
) (
    input  logic [exc_pkg::XLEN-1:0] status,
    output logic [exc_pkg::XLEN-1:0] vector
);
    assign vector = status[BEV_BIT] ? VEC_ROM : VEC_RAM;
endmodule

// File: rtl/exc_status_unit.sv
module exc_status_unit #(
    parameter int          LEVELS     = 3,
    parameter int          BEV_BIT    = 22,
    parameter logic [31:0] VEC_RAM    = 32'h8000_0080,
    parameter logic [31:0] VEC_ROM    = 32'hBFC0_0180,
    parameter logic [31:0] STATUS_RST = 32'h0040_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        trap_valid,
    input  logic        trap_kind,
    input  logic [31:0] trap_pc,
    input  logic        trap_in_delay,
    input  logic        rfe_valid,
    input  logic        cop_wr_en,
    input  logic [4:0]  cop_addr,
    input  logic [31:0] cop_wdata,
    output logic [31:0] cop_rdata,
    output logic        redirect_valid,
    output logic [31:0] redirect_vector,
    output logic        int_enable,
    output logic        user_mode
);
    import exc_pkg::*;

    exc_state_t state_d, state_q;

    logic [XLEN-1:0] status_next;
    logic [XLEN-1:0] cause_trap;
    logic [XLEN-1:0] epc_trap;
    logic [XLEN-1:0] vec_sel;
    logic [XLEN-1:0] status_cur;
    logic [XLEN-1:0] epc_cur;

    exc_status_stack #(.LEVELS(LEVELS)) u_stack (
        .status_in  (state_q.status),
        .push       (trap_valid),
        .pop        (rfe_valid & ~trap_valid),
        .status_out (status_next)
    );

    exc_trap_record u_record (
        .cause_in  (state_q.cause),
        .kind      (trap_kind_e'(trap_kind)),
        .pc        (trap_pc),
        .in_delay  (trap_in_delay),
        .cause_out (cause_trap),
        .epc_out   (epc_trap)
    );

    exc_vector_sel #(
        .BEV_BIT (BEV_BIT),
        .VEC_RAM (VEC_RAM),
        .VEC_ROM (VEC_ROM)
    ) u_vec (
        .status (state_q.status),
        .vector (vec_sel)
    );

    always_comb begin
        state_d             = state_q;
        state_d.redir_valid = 1'b0;
        if (trap_valid) begin
            state_d.status      = status_next;
            state_d.cause       = cause_trap;
            state_d.epc         = epc_trap;
            state_d.redir_valid = 1'b1;
            state_d.redir_vec   = vec_sel;
        end else if (rfe_valid) begin
            state_d.status = status_next;
        end else if (cop_wr_en) begin
            case (cop_addr)
                REG_STATUS: state_d.status = cop_wdata;
                REG_CAUSE:  state_d.cause  = cop_wdata;
                REG_EPC:    state_d.epc    = cop_wdata;
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.status      <= STATUS_RST;
            state_q.cause       <= '0;
            state_q.epc         <= '0;
            state_q.redir_valid <= 1'b0;
            state_q.redir_vec   <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        case (cop_addr)
            REG_STATUS: cop_rdata = state_q.status;
            REG_CAUSE:  cop_rdata = state_q.cause;
            REG_EPC:    cop_rdata = state_q.epc;
            default:    cop_rdata = '0;
        endcase
    end

    assign status_cur      = state_q.status;
    assign epc_cur         = state_q.epc;
    assign redirect_valid  = state_q.redir_valid;
    assign redirect_vector = state_q.redir_vec;
    assign int_enable      = state_q.status[0];
    assign user_mode       = state_q.status[1];
endmodule

// File: rtl/exc_status_unit_chk.sv
module exc_status_unit_chk #(
    parameter logic [31:0] VEC_RAM = 32'h8000_0080,
    parameter logic [31:0] VEC_ROM = 32'hBFC0_0180
) (
    input logic        clk,
    input logic        rst_n,
    input logic        trap_valid,
    input logic        trap_in_delay,
    input logic [31:0] trap_pc,
    input logic        rfe_valid,
    input logic [4:0]  cop_addr,
    input logic [31:0] cop_rdata,
    input logic        redirect_valid,
    input logic [31:0] redirect_vector,
    input logic        int_enable,
    input logic        user_mode,
    input logic [31:0] status_cur,
    input logic [31:0] epc_cur
);
    AST_TRAP_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |=> redirect_valid); // R8

    AST_NO_SPURIOUS_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_valid |=> !redirect_valid); // R8

    AST_VECTOR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> (redirect_vector == VEC_RAM || redirect_vector == VEC_ROM)); // R8

    AST_TRAP_KERNEL: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |=> (!int_enable && !user_mode)); // R6

    AST_TRAP_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |=> status_cur[31:6] == $past(status_cur[31:6])); // R6

    AST_EPC_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && !trap_in_delay) |=> epc_cur == $past(trap_pc)); // R4

    AST_EPC_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && trap_in_delay) |=> epc_cur == $past(trap_pc) - 32'd4); // R5

    AST_RFE_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (rfe_valid && !trap_valid) |=> status_cur[3:0] == $past(status_cur[5:2])); // R7

    AST_RFE_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (rfe_valid && !trap_valid) |=> status_cur[31:4] == $past(status_cur[31:4])); // R7

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cop_addr < 5'd12 || cop_addr > 5'd14) |-> cop_rdata == 32'd0); // R9
endmodule

bind exc_status_unit exc_status_unit_chk #(
    .VEC_RAM (VEC_RAM),
    .VEC_ROM (VEC_ROM)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .trap_valid      (trap_valid),
    .trap_in_delay   (trap_in_delay),
    .trap_pc         (trap_pc),
    .rfe_valid       (rfe_valid),
    .cop_addr        (cop_addr),
    .cop_rdata       (cop_rdata),
    .redirect_valid  (redirect_valid),
    .redirect_vector (redirect_vector),
    .int_enable      (int_enable),
    .user_mode       (user_mode),
    .status_cur      (status_cur),
    .epc_cur         (epc_cur)
);

// File: tb/exc_status_unit_bench.sv
`timescale 1ns/100ps
module exc_status_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trap_valid = 1'b0;
    logic        trap_kind = 1'b0;
    logic [31:0] trap_pc = '0;
    logic        trap_in_delay = 1'b0;
    logic        rfe_valid = 1'b0;
    logic        cop_wr_en = 1'b0;
    logic [4:0]  cop_addr = '0;
    logic [31:0] cop_wdata = '0;
    logic [31:0] cop_rdata;
    logic        redirect_valid;
    logic [31:0] redirect_vector;
    logic        int_enable;
    logic        user_mode;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [31:0] m_status, m_cause, m_epc, m_vec;
    logic        m_redir;

    always #4 clk = ~clk;

    exc_status_unit u_exc_status_unit (
        .clk, .rst_n, .trap_valid, .trap_kind, .trap_pc, .trap_in_delay,
        .rfe_valid, .cop_wr_en, .cop_addr, .cop_wdata, .cop_rdata,
        .redirect_valid, .redirect_vector, .int_enable, .user_mode
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] push_f(input logic [31:0] s);
        return {s[31:6], s[3:0], 2'b00};
    endfunction

    function automatic logic [31:0] pop_f(input logic [31:0] s);
        return {s[31:4], s[5:2]};
    endfunction

    task automatic read_all(input string st_tag, input string ca_tag, input string ep_tag);
        logic [4:0] ua;
        cop_wr_en = 1'b0;
        cop_addr = 5'd12; #0.5;
        chk(st_tag, "status", cop_rdata, m_status);
        cop_addr = 5'd13; #0.5;
        chk(ca_tag, "cause", cop_rdata, m_cause);
        cop_addr = 5'd14; #0.5;
        chk(ep_tag, "epc", cop_rdata, m_epc);
        ua = 5'($urandom % 32);
        if (ua >= 5'd12 && ua <= 5'd14) ua = 5'd31;
        cop_addr = ua; #0.5;
        chk("R9", "unmapped read", cop_rdata, 32'd0);
    endtask

    task automatic step(input bit tr, input bit kind, input logic [31:0] pc,
                        input bit dly, input bit rfe, input bit wr,
                        input logic [4:0] addr, input logic [31:0] wd);
        string st_tag, ca_tag, ep_tag;
        @(negedge clk);
        trap_valid = tr; trap_kind = kind; trap_pc = pc; trap_in_delay = dly;
        rfe_valid = rfe; cop_wr_en = wr; cop_addr = addr; cop_wdata = wd;
        st_tag = "R9"; ca_tag = "R9"; ep_tag = "R9";
        if (tr) begin
            m_vec    = m_status[22] ? 32'hBFC0_0180 : 32'h8000_0080;
            m_redir  = 1'b1;
            m_status = push_f(m_status);
            m_cause  = {dly, m_cause[30:7], kind ? 5'd9 : 5'd8, m_cause[1:0]};
            m_epc    = dly ? pc - 32'd4 : pc;
            st_tag   = (rfe || wr) ? "R10" : "R6";
            ca_tag   = kind ? "R3" : "R2";
            ep_tag   = dly ? "R5" : "R4";
        end else begin
            m_redir = 1'b0;
            if (rfe) begin
                m_status = pop_f(m_status);
                st_tag = wr ? "R10" : "R7";
                if (wr) begin ca_tag = "R10"; ep_tag = "R10"; end
            end else if (wr) begin
                case (addr)
                    5'd12: m_status = wd;
                    5'd13: m_cause  = wd;
                    5'd14: m_epc    = wd;
                    default: ;
                endcase
            end
        end
        @(posedge clk); #1;
        trap_valid = 1'b0; rfe_valid = 1'b0; cop_wr_en = 1'b0;
        chk("R8", "redirect_valid", {31'd0, redirect_valid}, {31'd0, m_redir});
        if (m_redir) chk("R8", "redirect_vector", redirect_vector, m_vec);
        chk("R11", "int_enable", {31'd0, int_enable}, {31'd0, m_status[0]});
        chk("R11", "user_mode", {31'd0, user_mode}, {31'd0, m_status[1]});
        read_all(st_tag, ca_tag, ep_tag);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        m_status = 32'h0040_0000; m_cause = '0; m_epc = '0; m_redir = 1'b0; m_vec = '0;
        repeat (3) @(posedge clk);
        #1;
        // R1: values while reset is held
        chk("R1", "redirect_valid in reset", {31'd0, redirect_valid}, 32'd0);
        chk("R1", "int_enable in reset", {31'd0, int_enable}, 32'd0);
        chk("R1", "user_mode in reset", {31'd0, user_mode}, 32'd0);
        read_all("R1", "R1", "R1");
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        read_all("R1", "R1", "R1");

        // Directed corners
        step(0, 0, 0, 0, 0, 1, 5'd12, 32'h0000_0003);         // R9 enable, user mode
        step(1, 0, 32'h0000_1000, 0, 0, 0, 0, 0);              // R2 R4 R6 R8 RAM vector
        step(0, 0, 0, 0, 1, 0, 0, 0);                          // R7 pop back
        step(0, 0, 0, 0, 0, 1, 5'd12, 32'h0040_003D);          // boot vector bit set
        step(1, 1, 32'h0000_2004, 1, 0, 0, 0, 0);              // R3 R5 ROM vector
        step(0, 0, 0, 0, 0, 0, 0, 0);                          // R8 redirect drops
        step(0, 0, 0, 0, 1, 0, 0, 0);                          // R7
        step(0, 0, 0, 0, 1, 0, 0, 0);                          // R7 top pair kept
        step(0, 0, 0, 0, 0, 1, 5'd11, 32'hFFFF_FFFF);          // R9 ignored write
        step(0, 0, 0, 0, 0, 1, 5'd15, 32'hFFFF_FFFF);          // R9 ignored write
        step(1, 0, 32'h0000_3000, 0, 1, 1, 5'd14, 32'h1234_5678); // R10 trap wins
        step(0, 0, 0, 0, 1, 1, 5'd13, 32'hAAAA_5555);          // R10 rfe drops write
        step(0, 0, 0, 0, 0, 1, 5'd13, 32'hFFFF_FF83);          // cause preset
        step(1, 1, 32'h0000_0000, 1, 0, 0, 0, 0);              // R5 wraps below zero

        // Constrained random
        for (int i = 0; i < 600; i++) begin
            int sel;
            bit tr, rfe, wr;
            sel = int'($urandom % 100);
            tr  = (sel < 25);
            rfe = (sel >= 25 && sel < 45) || (sel < 5);
            wr  = (sel >= 45 && sel < 80) || (sel < 8) || (sel >= 40 && sel < 45);
            step(tr, 1'($urandom % 2), $urandom & 32'hFFFF_FFFC, 1'($urandom % 2),
                 rfe, wr, 5'(10 + ($urandom % 7)), $urandom);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule